// File: doc/BRIEF.md
# Paired-Page Software-Managed Translation Buffer

This block is a small, fully associative translation buffer whose contents are maintained entirely by software. Each entry maps one virtual page pair (an even page and the odd page that follows it) to two independent physical frames. The size of the pair comes from a page-size field that is stored with the entry. An entry matches a lookup either because it is marked global or because its address-space identifier equals the one presented.

Software drives four operations through a set of register-shaped ports: the entry-high word (virtual tag and identifier), the two entry-low words (frame, attribute, dirty, valid and global bits for each half), the page-mask word, and the index word. The operations are write at the index, write at a caller-supplied random index, probe, and read back. A single-cycle busy phase follows each accepted request, and a one-cycle done pulse marks the moment the results appear. Results stay on the outputs until the next operation of the same kind replaces them.

Top module: `swTlb`

## Requirements
- R1: After reset `busy` and `done` are 0, all outputs are 0, and every entry holds all-zero fields.
- R2: A request with `opValid` high is accepted at a rising edge where `busy` is low. `busy` is then high for exactly one cycle, and `done` is high for the one cycle after that. A request presented while `busy` is high is ignored. Operation codes: 0 indexed write, 1 random write, 2 probe, 3 read.
- R3: An indexed write stores into entry `indexIn[IDXW-1:0]`, and the upper index bits are ignored. The stored fields are: tag = `entryHiIn[31:13]`, identifier = `entryHiIn[7:0]`, size = `pageMaskIn[24:13]`. For each half, valid = bit 1, dirty = bit 2, attribute = bits 5:3 and frame = bits 29:6 of its entry-low word.
- R4: A random write stores into entry `randIdx` as sampled with the request, regardless of `indexIn`.
- R5: The global bit of an entry is the AND of bit 0 of both entry-low words. A read of entry `indexIn[IDXW-1:0]` returns the entry-high word as tag in bits 31:13 and identifier in bits 7:0, with bits 12:8 at zero. It returns the page mask as size in bits 24:13. It returns each entry-low word as frame in bits 29:6, attribute, dirty and valid, with the global bit in bit 0 of both words.
- R6: A probe matches an entry when its tag equals `entryHiIn[31:13]` and the entry is either global or has an identifier equal to `entryHiIn[7:0]`.
- R7: On a probe hit, `indexOut` holds the matching entry number in bits IDXW-1:0 and zero in all other bits, bit 31 included. When several entries match, the lowest-numbered entry is reported.
- R8: On a probe miss, `indexOut` is `indexIn` with bit 31 set.
- R9: `indexOut` changes only through a probe. The entry-high, entry-low and page-mask outputs change only through a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation request |
| opCode | input | 2 | Operation select (see R2) |
| randIdx | input | IDXW | Entry number for a random write |
| entryHiIn | input | 32 | Virtual tag and identifier word |
| entryLo0In | input | 32 | Even-half mapping word |
| entryLo1In | input | 32 | Odd-half mapping word |
| pageMaskIn | input | 32 | Page-size word |
| indexIn | input | 32 | Entry number for indexed write and read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| entryHiOut | output | 32 | Entry-high word from a read |
| entryLo0Out | output | 32 | Even-half word from a read |
| entryLo1Out | output | 32 | Odd-half word from a read |
| pageMaskOut | output | 32 | Page-size word from a read |
| indexOut | output | 32 | Probe result |

## Verification
Every result has a fixed latency. `busy` is due one cycle after the accepting edge. `done`, the read words and the probe index are due two cycles after it. A write takes effect in time for any operation accepted on or after the done cycle. The bench drives requests on falling edges and samples on the falling edge that follows each counted rising edge, so it checks `busy` one falling edge after the request and checks `done` and the outputs one falling edge later. A write is checked by a later read or probe, and the hold rule is checked by comparing the outputs before and after an operation of the other kind.

// File: rtl/tlbPkg.sv
package tlbPkg;

  localparam int TAG_W  = 19;
  localparam int ASID_W = 8;
  localparam int SIZE_W = 12;
  localparam int PFN_W  = 24;
  localparam int ATTR_W = 3;

  typedef enum logic [1:0] {
    OP_WR_IDX = 2'd0,
    OP_WR_RND = 2'd1,
    OP_PROBE  = 2'd2,
    OP_READ   = 2'd3
  } tlbOp_e;

  typedef struct packed {
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
    logic              dirty;
    logic              valid;
  } tlbHalf_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic [SIZE_W-1:0] size;
    logic              glob;
    tlbHalf_t          even;
    tlbHalf_t          odd;
  } tlbEntry_t;

  typedef struct packed {
    logic capture;
    logic doWrite;
    logic useRand;
    logic doProbe;
    logic doRead;
  } tlbStrobe_t;

  function automatic tlbHalf_t loToHalf(input logic [31:0] lo);
    tlbHalf_t h;
    h.pfn   = lo[29:6];
    h.attr  = lo[5:3];
    h.dirty = lo[2];
    h.valid = lo[1];
    return h;
  endfunction

  function automatic logic [31:0] halfToLo(input tlbHalf_t h, input logic g);
    return {2'b00, h.pfn, h.attr, h.dirty, h.valid, g};
  endfunction

  function automatic tlbEntry_t makeEntry(input logic [31:0] hi, input logic [31:0] lo0,
                                          input logic [31:0] lo1, input logic [31:0] pm);
    tlbEntry_t e;
    e.tag  = hi[31:13];
    e.asid = hi[7:0];
    e.size = pm[24:13];
    e.glob = lo0[0] & lo1[0];
    e.even = loToHalf(lo0);
    e.odd  = loToHalf(lo1);
    return e;
  endfunction

endpackage

// File: rtl/tlbPrioEnc.sv
module tlbPrioEnc #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  hitVec,
  output logic          hit,
  output logic [IW-1:0] hitIdx
);

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hit    = 1'b1;
        hitIdx = IW'(i);
      end
    end
  end

  always_comb begin
    if (hit) begin
      AST_HIT_IS_MATCH: assert (hitVec[hitIdx]); // R7
      AST_LOWEST_WINS: assert ((hitVec & ((N'(1) << hitIdx) - N'(1))) == '0); // R7
    end else begin
      AST_MISS_NO_MATCH: assert (hitVec == '0); // R8
    end
  end

endmodule

// File: rtl/tlbCtrl.sv
module tlbCtrl
  import tlbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opCode,
  output logic       busy,
  output logic       done,
  output tlbStrobe_t strobe
);

  logic   busyQ;
  logic   doneQ;
  tlbOp_e opQ;
  logic   accept;

  assign accept = opValid && !busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      opQ   <= OP_WR_IDX;
    end else begin
      busyQ <= accept;
      doneQ <= busyQ;
      if (accept) opQ <= tlbOp_e'(opCode);
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.capture = accept;
    strobe.doWrite = busyQ && ((opQ == OP_WR_IDX) || (opQ == OP_WR_RND));
    strobe.useRand = opQ == OP_WR_RND;
    strobe.doProbe = busyQ && (opQ == OP_PROBE);
    strobe.doRead  = busyQ && (opQ == OP_READ);
  end

  assign busy = busyQ;
  assign done = doneQ;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |=> (!busyQ && doneQ)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R2
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && opValid) |=> !busyQ); // R2
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doWrite, strobe.doProbe, strobe.doRead})); // R2

endmodule

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDXW    = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  tlbStrobe_t      strobe,
  input  logic [IDXW-1:0] randIdx,
  input  logic [31:0]     entryHiIn,
  input  logic [31:0]     entryLo0In,
  input  logic [31:0]     entryLo1In,
  input  logic [31:0]     pageMaskIn,
  input  logic [31:0]     indexIn,
  output logic [31:0]     entryHiOut,
  output logic [31:0]     entryLo0Out,
  output logic [31:0]     entryLo1Out,
  output logic [31:0]     pageMaskOut,
  output logic [31:0]     indexOut
);

  tlbEntry_t       entryQ [ENTRIES];
  tlbEntry_t       pendQ;
  logic [31:0]     idxQ;
  logic [IDXW-1:0] randQ;
  logic [IDXW-1:0] writeIdx;
  logic [IDXW-1:0] readIdx;
  tlbEntry_t       rdEntry;
  logic [ENTRIES-1:0] hitVec;
  logic            probeHit;
  logic [IDXW-1:0] probeIdx;
  logic            unusedIn;

  assign unusedIn = &{1'b0, entryHiIn[12:8], entryLo0In[31:30], entryLo1In[31:30],
                      pageMaskIn[31:25], pageMaskIn[12:0]};

  // Operand capture at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      idxQ  <= '0;
      randQ <= '0;
    end else if (strobe.capture) begin
      pendQ <= makeEntry(entryHiIn, entryLo0In, entryLo1In, pageMaskIn);
      idxQ  <= indexIn;
      randQ <= randIdx;
    end
  end

  assign writeIdx = strobe.useRand ? randQ : idxQ[IDXW-1:0];
  assign readIdx  = idxQ[IDXW-1:0];

  // Entry storage and match lines, one slice per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryQ[e] <= '0;
      end else if (strobe.doWrite && (writeIdx == IDXW'(e))) begin
        entryQ[e] <= pendQ;
      end
    end

    assign hitVec[e] = (entryQ[e].glob || (entryQ[e].asid == pendQ.asid)) &&
                       (entryQ[e].tag == pendQ.tag);
  end

  tlbPrioEnc #(.N(ENTRIES), .IW(IDXW)) uEnc (
    .hitVec (hitVec),
    .hit    (probeHit),
    .hitIdx (probeIdx)
  );

  assign rdEntry = entryQ[readIdx];

  // Result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryHiOut  <= '0;
      entryLo0Out <= '0;
      entryLo1Out <= '0;
      pageMaskOut <= '0;
      indexOut    <= '0;
    end else begin
      if (strobe.doProbe) begin
        if (probeHit) indexOut <= {{(32-IDXW){1'b0}}, probeIdx};
        else          indexOut <= {1'b1, idxQ[30:0]};
      end
      if (strobe.doRead) begin
        entryHiOut  <= {rdEntry.tag, 5'b00000, rdEntry.asid};
        pageMaskOut <= {7'b0000000, rdEntry.size, 13'b0};
        entryLo0Out <= halfToLo(rdEntry.even, rdEntry.glob);
        entryLo1Out <= halfToLo(rdEntry.odd, rdEntry.glob);
      end
    end
  end

  AST_PROBE_HIT_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doProbe && probeHit) |=> (indexOut[31:IDXW] == '0)); // R7
  AST_PROBE_MISS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doProbe && !probeHit) |=> (indexOut[31] && (indexOut[30:0] == $past(idxQ[30:0])))); // R8
  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doProbe |=> $stable(indexOut)); // R9
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doRead |=> ($stable(entryHiOut) && $stable(entryLo0Out) && $stable(pageMaskOut))); // R9
  AST_GLOBAL_REPLICA: assert property (@(posedge clk) disable iff (!rstN)
    entryLo0Out[0] == entryLo1Out[0]); // R5
  AST_HI_GAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    entryHiOut[12:8] == 5'b00000); // R5

endmodule

// File: rtl/swTlb.sv
module swTlb
  import tlbPkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IDXW    = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [1:0]      opCode,
  input  logic [IDXW-1:0] randIdx,
  input  logic [31:0]     entryHiIn,
  input  logic [31:0]     entryLo0In,
  input  logic [31:0]     entryLo1In,
  input  logic [31:0]     pageMaskIn,
  input  logic [31:0]     indexIn,
  output logic            busy,
  output logic            done,
  output logic [31:0]     entryHiOut,
  output logic [31:0]     entryLo0Out,
  output logic [31:0]     entryLo1Out,
  output logic [31:0]     pageMaskOut,
  output logic [31:0]     indexOut
);

  tlbStrobe_t strobe;

  tlbCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .busy    (busy),
    .done    (done),
    .strobe  (strobe)
  );

  tlbDatapath #(.ENTRIES(ENTRIES), .IDXW(IDXW)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .randIdx     (randIdx),
    .entryHiIn   (entryHiIn),
    .entryLo0In  (entryLo0In),
    .entryLo1In  (entryLo1In),
    .pageMaskIn  (pageMaskIn),
    .indexIn     (indexIn),
    .entryHiOut  (entryHiOut),
    .entryLo0Out (entryLo0Out),
    .entryLo1Out (entryLo1Out),
    .pageMaskOut (pageMaskOut),
    .indexOut    (indexOut)
  );

endmodule

// File: tb/tb_swTlb.sv
module tb_swTlb;

  localparam int ENTRIES = 16;
  localparam int IDXW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opCode = 2'd0;
  logic [IDXW-1:0] randIdx = '0;
  logic [31:0] entryHiIn = '0, entryLo0In = '0, entryLo1In = '0, pageMaskIn = '0, indexIn = '0;
  logic busy, done;
  logic [31:0] entryHiOut, entryLo0Out, entryLo1Out, pageMaskOut, indexOut;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  swTlb #(.ENTRIES(ENTRIES)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .randIdx(randIdx),
    .entryHiIn(entryHiIn), .entryLo0In(entryLo0In), .entryLo1In(entryLo1In),
    .pageMaskIn(pageMaskIn), .indexIn(indexIn), .busy(busy), .done(done),
    .entryHiOut(entryHiOut), .entryLo0Out(entryLo0Out), .entryLo1Out(entryLo1Out),
    .pageMaskOut(pageMaskOut), .indexOut(indexOut)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one operation; returns at the falling edge where done is due.
  task automatic doOp(input logic [1:0] code, input logic [31:0] hi, input logic [31:0] lo0,
                      input logic [31:0] lo1, input logic [31:0] pm, input logic [31:0] idx,
                      input logic [IDXW-1:0] rnd);
    @(negedge clk);
    chk("R2", "done low before request", {31'b0, done}, 32'd0);
    opValid = 1'b1; opCode = code; entryHiIn = hi; entryLo0In = lo0;
    entryLo1In = lo1; pageMaskIn = pm; indexIn = idx; randIdx = rnd;
    @(negedge clk);
    opValid = 1'b0;
    chk("R2", "busy one cycle after accept", {31'b0, busy}, 32'd1);
    @(negedge clk);
    chk("R2", "done two cycles after accept", {30'b0, busy, done}, 32'd1);
  endtask

  task automatic readExpect(input string req, input logic [31:0] idx, input logic [31:0] hi,
                            input logic [31:0] lo0, input logic [31:0] lo1, input logic [31:0] pm);
    doOp(2'd3, 32'h0, 32'h0, 32'h0, 32'h0, idx, '0);
    chk(req, "read entryHi", entryHiOut, hi);
    chk(req, "read entryLo0", entryLo0Out, lo0);
    chk(req, "read entryLo1", entryLo1Out, lo1);
    chk(req, "read pageMask", pageMaskOut, pm);
  endtask

  task automatic probeExpect(input string req, input logic [31:0] hi, input logic [31:0] idx,
                             input logic [31:0] exp);
    doOp(2'd2, hi, 32'h0, 32'h0, 32'h0, idx, '0);
    chk(req, "probe index", indexOut, exp);
  endtask

  task automatic testReset();
    chk("R1", "busy/done after reset", {30'b0, busy, done}, 32'd0);
    chk("R1", "indexOut after reset", indexOut, 32'd0);
    chk("R1", "entryHiOut after reset", entryHiOut, 32'd0);
    readExpect("R1", 32'd5, 32'd0, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic testIndexedWrite();
    // Index 0x13 selects entry 3: upper bits ignored (R3); lo1 bit0 = 0 so not global (R5)
    doOp(2'd0, 32'h2468_BF11, 32'hC000_00F7, 32'h0000_1236, 32'hFFFF_FFFF, 32'h0000_0013, 4'd0);
    readExpect("R3", 32'd3, 32'h2468_A011, 32'h0000_00F6, 32'h0000_1236, 32'h01FF_E000);
  endtask

  task automatic testRandomWrite();
    // Random write to entry 9 with both global bits set; indexIn points at 0
    doOp(2'd1, 32'h1357_E0AA, 32'h0000_0041, 32'h0000_0081, 32'h0000_6000, 32'd0, 4'd9);
    readExpect("R4", 32'd9, 32'h1357_E0AA, 32'h0000_0041, 32'h0000_0081, 32'h0000_6000);
    readExpect("R4", 32'd0, 32'd0, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic testProbes();
    probeExpect("R6", 32'h2468_A011, 32'd0, 32'h0000_0003);
    probeExpect("R8", 32'h2468_A055, 32'h0000_0007, 32'h8000_0007);
    probeExpect("R8", 32'h2468_C011, 32'h0000_0002, 32'h8000_0002);
    probeExpect("R6", 32'h1357_E022, 32'd0, 32'h0000_0009);
  endtask

  task automatic testDuplicates();
    // Entry 12: same tag as entry 9, global. Entry 1: same tag, not global, id 0x33
    doOp(2'd0, 32'h1357_E044, 32'h1, 32'h1, 32'h0, 32'd12, '0);
    doOp(2'd0, 32'h1357_E033, 32'h1, 32'h0, 32'h0, 32'd1, '0);
    probeExpect("R7", 32'h1357_E033, 32'hFFFF_FFFF, 32'h0000_0001);
    probeExpect("R7", 32'h1357_E044, 32'd0, 32'h0000_0009);
  endtask

  task automatic testHold();
    logic [31:0] hiBefore;
    hiBefore = entryHiOut;
    probeExpect("R9", 32'h2468_A011, 32'd0, 32'h0000_0003);
    chk("R9", "entryHi held over probe", entryHiOut, hiBefore);
    doOp(2'd0, 32'hFFFF_FFFF, 32'h3, 32'h3, 32'h0, 32'd14, '0);
    chk("R9", "index held over write", indexOut, 32'h0000_0003);
    chk("R9", "entryHi held over write", entryHiOut, hiBefore);
  endtask

  task automatic testBusyIgnore();
    @(negedge clk);
    opValid = 1'b1; opCode = 2'd3; indexIn = 32'd3;
    @(negedge clk);
    chk("R2", "busy after accept", {31'b0, busy}, 32'd1);
    // Keep requesting a write to entry 7 while busy
    opCode = 2'd0; entryHiIn = 32'hABCD_E0FF; entryLo0In = 32'h7; entryLo1In = 32'h7;
    pageMaskIn = 32'h0; indexIn = 32'd7;
    @(negedge clk);
    opValid = 1'b0;
    chk("R2", "done while request held", {30'b0, busy, done}, 32'd1);
    chk("R2", "first read result", entryHiOut, 32'h2468_A011);
    @(negedge clk);
    chk("R2", "no second operation", {30'b0, busy, done}, 32'd0);
    readExpect("R2", 32'd7, 32'd0, 32'd0, 32'd0, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIndexedWrite();
    testRandomWrite();
    testProbes();
    testDuplicates();
    testHold();
    testBusyIgnore();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule